// File: doc/BRIEF.md
# Fractional Hundredths Tick Generator

This block produces an exact long-term 100 Hz tick from a 4096 Hz enable strobe. The block runs in the system clock domain. The strobe ratio of 40.96 is not an integer, so the block builds it from two integer divisors. It counts 25 output periods as one frame. Each of the first 24 periods uses 41 strobes and the final period uses 40. One frame therefore uses exactly 1024 strobes, which is 250 ms. Individual tick spacing varies slightly, but the tick count is exact at every frame boundary.

The block also drives a 1024 Hz square wave, derived from the same strobe and locked in phase to the frame. A stop control freezes all counting, as a stopped oscillator would. A square-wave disable control turns the square-wave output enable off.

Control is a three-state machine:
- `ST_LONG`: periods 0 to 23, divisor 41.
- `ST_SHORT`: period 24, divisor 40.
- `ST_HALT`: stopped.

Transitions:
- `ST_LONG -> ST_SHORT` when period 23 completes.
- `ST_SHORT -> ST_LONG` when period 24 completes, with the slot index wrapping to 0.
- `ST_LONG -> ST_HALT` and `ST_SHORT -> ST_HALT` while `osc_halt` is 1.
- `ST_HALT -> ST_SHORT` on release if the stored slot index is 24.
- `ST_HALT -> ST_LONG` on release otherwise.

Top module: `hundredths_tick_gen`

## Requirements
- R1: In slots 0 to 23, a tick is issued on the 41st accepted strobe of the period. Strobes are counted as an enable, once per clock cycle in which `strobe_4k` is 1, so back-to-back strobes each count.
- R2: Slot 24 completes on its 40th accepted strobe. The slot index then returns to 0.
- R3: From reset, every 1024 accepted strobes yield exactly 25 ticks. The 25th tick falls on the 1024th strobe.
- R4: `tick_100` is high for exactly one clock cycle. That cycle is the one after the rising edge that samples the strobe completing a period. In all other cycles `tick_100` is 0.
- R5: While `osc_halt` is 1, strobes are ignored. No tick is produced, and the period count, slot index and square-wave phase hold. A strobe in the first cycle after `osc_halt` falls is also ignored. Counting then resumes from the held position.
- R6: The square-wave phase counts accepted strobes modulo 4. `sqw_level` is 1 when that count (after the current edge) is 2 or 3 and `sqw_oe` is 1. The level therefore toggles every 2 strobes and realigns to 0 at each frame start.
- R7: When `sqw_off` is 1, `sqw_oe` and `sqw_level` are 0 from the next edge on. The phase keeps counting.
- R8: After reset, `tick_100`, `sqw_level` and `sqw_oe` are 0, and counting starts at slot 0 with a period count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_4k | input | 1 | 4096 Hz enable, one clock wide per strobe |
| osc_halt | input | 1 | 1 stops all counting |
| sqw_off | input | 1 | 1 disables the square-wave output |
| tick_100 | output | 1 | One-cycle 100 Hz tick |
| sqw_level | output | 1 | 1024 Hz square-wave level |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
The bench targets the following corner cases:
- **Short period.** A design that placed the 40-strobe period anywhere other than slot 24, or used 41 everywhere, would drift off the 1024-strobe frame. The tick-position and frame-count checks expose this.
- **Release cycle.** Strobes arrive exactly as `osc_halt` rises and in the cycle it falls. A design that counted the release-cycle strobe, or lost its place while halted, would shift every later tick.
- **Back-to-back strobes.** Continuous strobes check that every enabled cycle counts.
- **Square-wave enable.** Toggling `sqw_off` mid-phase checks that the phase keeps running while the output is gated.

// File: rtl/htg_pkg.sv
package htg_pkg;
    typedef enum logic [1:0] {
        ST_LONG  = 2'd0,
        ST_SHORT = 2'd1,
        ST_HALT  = 2'd2
    } htg_state_e;
endpackage

// File: rtl/htg_seq_fsm.sv
module htg_seq_fsm
    import htg_pkg::*;
#(
    parameter int LONG_SLOTS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic osc_halt,
    input  logic period_done,
    output logic accept,
    output logic short_sel
);
    localparam int SLOTS = LONG_SLOTS + 1;
    localparam int SEQ_W = $clog2(SLOTS);
    localparam logic [SEQ_W-1:0] LAST_LONG = SEQ_W'(LONG_SLOTS - 1);
    localparam logic [SEQ_W-1:0] SHORT_IDX = SEQ_W'(LONG_SLOTS);

    htg_state_e state_q, state_d;
    logic [SEQ_W-1:0] seq_q, seq_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LONG;
            seq_q   <= '0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        seq_d   = seq_q;
        if (period_done)
            seq_d = (seq_q == SHORT_IDX) ? '0 : seq_q + 1'b1;
        unique case (state_q)
            ST_LONG: begin
                if (osc_halt)
                    state_d = ST_HALT;
                else if (period_done && seq_q == LAST_LONG)
                    state_d = ST_SHORT;
            end
            ST_SHORT: begin
                if (osc_halt)
                    state_d = ST_HALT;
                else if (period_done)
                    state_d = ST_LONG;
            end
            ST_HALT: begin
                if (!osc_halt)
                    state_d = (seq_q == SHORT_IDX) ? ST_SHORT : ST_LONG;
            end
            default: state_d = ST_LONG;
        endcase
    end

    // outputs
    always_comb begin
        accept    = strobe && !osc_halt && (state_q != ST_HALT);
        short_sel = (state_q == ST_SHORT);
    end

    // R2: the short divisor is used only in the last slot
    assert_short_last_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHORT) |-> (seq_q == SHORT_IDX));
    assert_seq_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q <= SHORT_IDX);
    // R5: slot index frozen while halted
    assert_halt_seq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_halt |=> $stable(seq_q));
endmodule

// File: rtl/htg_period_ctr.sv
module htg_period_ctr #(
    parameter int DIV_LONG  = 41,
    parameter int DIV_SHORT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic short_sel,
    input  logic osc_halt,
    output logic period_done
);
    localparam int CNT_W = $clog2(DIV_LONG);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(DIV_LONG - 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(DIV_SHORT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit       = short_sel ? LIM_SHORT : LIM_LONG;
        period_done = accept && (cnt_q == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (accept)
            cnt_q <= period_done ? '0 : cnt_q + 1'b1;
    end

    // R1: count never passes the long limit
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_LONG);
    // R5: count frozen while halted
    assert_halt_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_halt |=> $stable(cnt_q));
endmodule

// File: rtl/htg_sqw_gen.sv
module htg_sqw_gen #(
    parameter int SQW_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic sqw_off,
    output logic sqw_level,
    output logic sqw_oe
);
    localparam int HB    = $clog2(SQW_HALF);
    localparam int PH_W  = HB + 1;

    logic [PH_W-1:0] phase_q, phase_d;

    always_comb phase_d = accept ? phase_q + 1'b1 : phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            sqw_level <= 1'b0;
            sqw_oe    <= 1'b0;
        end else begin
            phase_q   <= phase_d;
            sqw_level <= phase_d[HB] && !sqw_off;
            sqw_oe    <= !sqw_off;
        end
    end

    // R6: phase moves only on accepted strobes
    assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(phase_q));
    // R7: disabled output stays quiet
    assert_sqw_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_off |=> (!sqw_level && !sqw_oe));
endmodule

// File: rtl/hundredths_tick_gen.sv
module hundredths_tick_gen #(
    parameter int DIV_LONG   = 41,
    parameter int DIV_SHORT  = 40,
    parameter int LONG_SLOTS = 24,
    parameter int SQW_HALF   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_4k,
    input  logic osc_halt,
    input  logic sqw_off,
    output logic tick_100,
    output logic sqw_level,
    output logic sqw_oe
);
    logic accept;
    logic short_sel;
    logic period_done;

    htg_seq_fsm #(.LONG_SLOTS(LONG_SLOTS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe      (strobe_4k),
        .osc_halt    (osc_halt),
        .period_done (period_done),
        .accept      (accept),
        .short_sel   (short_sel)
    );

    htg_period_ctr #(.DIV_LONG(DIV_LONG), .DIV_SHORT(DIV_SHORT)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .short_sel   (short_sel),
        .osc_halt    (osc_halt),
        .period_done (period_done)
    );

    htg_sqw_gen #(.SQW_HALF(SQW_HALF)) u_sqw (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .sqw_off   (sqw_off),
        .sqw_level (sqw_level),
        .sqw_oe    (sqw_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) tick_100 <= 1'b0;
        else        tick_100 <= period_done;
    end

    // R4: a tick never lasts two cycles
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_100 |=> !tick_100);
    // R5: no tick follows a halted cycle
    assert_no_tick_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        osc_halt |=> !tick_100);
endmodule

// File: tb/tb_hundredths_tick_gen.sv
module tb_hundredths_tick_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_4k = 1'b0, osc_halt = 1'b0, sqw_off = 1'b0;
    logic tick_100, sqw_level, sqw_oe;

    always #2 clk = ~clk;  // 250 MHz

    hundredths_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .strobe_4k(strobe_4k), .osc_halt(osc_halt),
        .sqw_off(sqw_off), .tick_100(tick_100), .sqw_level(sqw_level), .sqw_oe(sqw_oe)
    );

    int vectors = 0, errs = 0, cyc = 0;
    bit done_flag = 0;
    // reference model state
    int m_cnt = 0, m_seq = 0, m_phase = 0, m_acc = 0, m_ticks = 0;
    bit m_halted = 0;
    bit e_tick = 0, e_lvl = 0, e_oe = 0;
    int tick_at[$];

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_seq = 0; m_phase = 0; m_acc = 0; m_ticks = 0;
        m_halted = 0; e_tick = 0; e_lvl = 0; e_oe = 0;
    endtask

    task automatic step(input bit s, input bit h, input bit o);
        bit acc;
        int len;
        strobe_4k = s; osc_halt = h; sqw_off = o;
        @(posedge clk);
        acc = s && !h && !m_halted;   // R5 release-cycle strobe ignored
        m_halted = h;
        len = (m_seq == 24) ? 40 : 41; // R1 / R2
        e_tick = 0;
        if (acc) begin
            m_acc++;
            m_phase = (m_phase + 1) % 4;
            if (m_cnt == len - 1) begin
                e_tick = 1; m_cnt = 0; m_seq = (m_seq + 1) % 25;
                m_ticks++; tick_at.push_back(m_acc);
            end else m_cnt++;
        end
        e_oe = !o;
        e_lvl = !o && (m_phase >= 2);
        @(negedge clk);
        chk("R4 tick_100", tick_100, e_tick);
        chk("R6 sqw_level", sqw_level, e_lvl);
        chk("R7 sqw_oe", sqw_oe, e_oe);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        strobe_4k = 0; osc_halt = 0; sqw_off = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        tick_at.delete();
        // R8: reset state
        chk("R8 tick_100", tick_100, 1'b0);
        chk("R8 sqw_level", sqw_level, 1'b0);
        chk("R8 sqw_oe", sqw_oe, 1'b0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            finish_run();
        end
    end

    initial begin
        int t0;
        @(negedge clk);
        do_reset();

        // R1 R2 R3: two frames, strobe every third cycle
        for (int i = 0; i < 2048; i++) begin
            step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
        end
        chk_int("R3 ticks in two frames", m_ticks, 50);
        for (int n = 1; n <= 24; n++)
            chk_int("R1 tick position", tick_at[n-1], 41 * n);
        chk_int("R2 short slot end", tick_at[24], 1024);
        chk_int("R3 second frame end", tick_at[49], 2048);

        // R1: back-to-back strobes
        for (int i = 0; i < 120; i++) step(1, 0, 0);

        // R5: halt with strobes, release with a strobe
        t0 = m_ticks;
        for (int i = 0; i < 60; i++) step(1, 1, 0);
        chk_int("R5 no tick while halted", m_ticks, t0);
        step(1, 0, 0);   // release-cycle strobe ignored
        for (int i = 0; i < 300; i++) begin step(1, 0, 0); step(0, 0, 0); end
        for (int i = 0; i < 10; i++) begin step(1, 0, 0); step(0, 1, 0); step(1, 1, 0); end

        // R7: square wave gated while phase keeps running
        for (int i = 0; i < 40; i++) begin step(1, 0, i % 7 < 3); step(0, 0, i % 5 == 0); end

        // R8: reset mid-run then R3 a fresh frame
        do_reset();
        for (int i = 0; i < 1024; i++) begin step(1, 0, 0); step(0, 0, 0); end
        chk_int("R3 fresh frame", m_ticks, 25);
        chk_int("R2 fresh frame end", tick_at[24], 1024);
        finish_run();
    end
endmodule